// File: doc/BRIEF.md
# Paged Address Translator with Small Associative Cache

The block turns a 16-bit logical address into a physical address. The upper byte of the address selects a page, and the lower byte is the position inside that page. The translator first looks the page up in a four-slot, fully associative translation cache. When the cache has no entry for the page, it reads a 256-entry page map held inside the block. It then copies the page's mapping into the cache so that later references find it there. The physical address is the frame number from the mapping placed above the unchanged in-page offset.

Each map entry holds a frame number, a presence flag and a write-permission flag. A reference to an absent page returns a missing-page fault. A write to a page without write permission returns a permission fault. Neither fault issues an address. Software fills the map through a one-cycle write port. Rewriting a map entry drops any cached copy of that page, and a flush input empties the cache. Two counters record how many accepted requests hit and how many missed, so the hit ratio can be measured.

A request is offered by raising `reqValid` for one cycle while `busy` is low. On a hit the result shows on the next cycle. On a miss `busy` rises for one cycle, and the result follows one cycle later.

Top module: `paged_xlate`

## Requirements
- R1: A request accepted while its page is cached gives, one cycle later, `respValid`=1, `respFault`=0 and `respAddr` = {frame, logical address bits 7:0}, and `busy` stays low.
- R2: A request accepted while its page is not cached raises `busy` for exactly one cycle; the result follows one cycle after that, two cycles after acceptance, and the page is then cached so the next reference to it hits.
- R3: A reference to a page whose map entry has the presence flag clear gives `respFault`=1 with `respAddr`=0, and installs nothing in the cache, so a repeat reference misses again.
- R4: A write (`reqWrite`=1) to a page whose write-permission flag is clear gives `respFault`=2 with `respAddr`=0; a read of the same page translates normally.
- R5: A fill uses the lowest-numbered empty cache slot; when all four slots are full, victims are taken in round-robin slot order, starting from slot 0 after reset.
- R6: `flush` empties every cache slot, so each later page reference misses until refilled.
- R7: A map write (`tblWe`) removes only the cached copy of the written page; the next reference to that page misses and returns the new frame, while other cached pages still hit.
- R8: While `busy` is high, `reqValid` is ignored: no counter changes and no extra result is produced.
- R9: `hitCount` and `missCount` each rise by one per accepted hit or miss.
- R10: A map write to the page being filled, in the fill cycle, leaves that cycle's result built from the old entry and installs nothing, so the next reference misses and sees the new entry.
- R11: After reset `respValid`=0, `busy`=0, both counters are 0, the cache is empty and every map entry is marked absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Offer a translation request this cycle |
| reqAddr | input | 16 | Logical address: page in bits 15:8, offset in bits 7:0 |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| busy | output | 1 | High during the map-read/fill cycle of a miss |
| respValid | output | 1 | Result valid this cycle |
| respAddr | output | 16 | Physical address, 0 on a fault |
| respFault | output | 2 | 0 none, 1 missing page, 2 write not permitted |
| flush | input | 1 | Empty the translation cache |
| tblWe | input | 1 | Write one page-map entry |
| tblPage | input | 8 | Page number of the entry written |
| tblFrame | input | 8 | Frame number stored |
| tblValid | input | 1 | Presence flag stored |
| tblWritable | input | 1 | Write-permission flag stored |
| hitCount | output | 16 | Accepted requests that hit |
| missCount | output | 16 | Accepted requests that missed |

## Verification
Two events can collide in one cycle: a map rewrite and the fill of the same page. The bench starts a miss on a page and drives `tblWe` for that page while `busy` is high. It then checks that the result still carries the old frame. A second reference to the page must miss and return the new frame, which shows that no stale copy was cached. A related overlap, a request offered while the fill cycle runs, is judged from the counters and from the single result that appears.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_INVALID = 2'd1,
    FAULT_PROTECT = 2'd2
  } fault_e;

  typedef struct packed {
    logic acceptHit;
    logic acceptMiss;
    logic doFill;
  } ctrlStrobe_t;

endpackage

// File: rtl/xlate_ptable.sv
module xlate_ptable #(
  parameter int PAGE_W  = 8,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [PAGE_W-1:0]  wrPage,
  input  logic [FRAME_W-1:0] wrFrame,
  input  logic               wrValid,
  input  logic               wrWritable,
  input  logic [PAGE_W-1:0]  rdPage,
  output logic [FRAME_W-1:0] rdFrame,
  output logic               rdValid,
  output logic               rdWritable
);

  localparam int DEPTH = 1 << PAGE_W;

  logic [DEPTH-1:0]   presentMap;
  logic [FRAME_W-1:0] frameMem [DEPTH];
  logic [DEPTH-1:0]   writeMap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presentMap <= '0;
    end else if (wrEn) begin
      presentMap[wrPage] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      frameMem[wrPage] <= wrFrame;
      writeMap[wrPage] <= wrWritable;
    end
  end

  assign rdFrame    = frameMem[rdPage];
  assign rdValid    = presentMap[rdPage];
  assign rdWritable = writeMap[rdPage];

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             tlbHit,
  output logic             busy,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  typedef enum logic {ST_LOOKUP, ST_FILL} state_e;
  state_e state;

  assign busy = (state == ST_FILL);

  always_comb begin
    strobe.acceptHit  = reqValid && !busy && tlbHit;
    strobe.acceptMiss = reqValid && !busy && !tlbHit;
    strobe.doFill     = (state == ST_FILL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOOKUP;
    end else if (strobe.acceptMiss) begin
      state <= ST_FILL;
    end else begin
      state <= ST_LOOKUP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strobe.acceptHit)  hitCount  <= hitCount + CNT_W'(1);
      if (strobe.acceptMiss) missCount <= missCount + CNT_W'(1);
    end
  end

  // R2: the fill phase lasts a single cycle
  assert_fill_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R2: an accepted miss enters the fill phase
  assert_miss_enters_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptMiss |=> busy);

  // R1: a hit never stalls
  assert_hit_no_stall_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptHit |=> !busy);

  // R8: requests offered during the fill cycle are not counted
  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (hitCount == $past(hitCount)) && (missCount == $past(missCount)));

  // R9: each accepted hit advances the hit counter by one
  assert_hit_counted_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptHit |=> hitCount == $past(hitCount) + CNT_W'(1));

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int TLB_N   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PAGE_W+OFF_W-1:0]  reqAddr,
  input  logic                     reqWrite,
  input  ctrlStrobe_t              strobe,
  input  logic                     flush,
  input  logic                     tblWe,
  input  logic [PAGE_W-1:0]        tblPage,
  output logic                     tlbHit,
  output logic [PAGE_W-1:0]        ptIdx,
  input  logic [FRAME_W-1:0]       pteFrame,
  input  logic                     pteValid,
  input  logic                     pteWritable,
  output logic                     respValid,
  output logic [FRAME_W+OFF_W-1:0] respAddr,
  output logic [1:0]               respFault
);

  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int PHYS_W = FRAME_W + OFF_W;
  localparam int IDX_W  = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [PAGE_W-1:0] reqPage;
  logic [OFF_W-1:0]  reqOff;
  assign reqPage = reqAddr[ADDR_W-1:OFF_W];
  assign reqOff  = reqAddr[OFF_W-1:0];

  // request held across the fill cycle
  logic [PAGE_W-1:0] latPage;
  logic [OFF_W-1:0]  latOff;
  logic              latWrite;

  always_ff @(posedge clk) begin
    if (strobe.acceptMiss) begin
      latPage  <= reqPage;
      latOff   <= reqOff;
      latWrite <= reqWrite;
    end
  end

  assign ptIdx = latPage;

  // cache slots
  logic [TLB_N-1:0]   slotValid;
  logic [PAGE_W-1:0]  slotPage  [TLB_N];
  logic [FRAME_W-1:0] slotFrame [TLB_N];
  logic [TLB_N-1:0]   slotWr;
  logic [TLB_N-1:0]   hitVec;

  for (genvar g = 0; g < TLB_N; g++) begin : g_match
    assign hitVec[g] = slotValid[g] && (slotPage[g] == reqPage);
  end

  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             freeFound;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  always_comb begin
    freeIdx   = '0;
    freeFound = 1'b0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (!slotValid[i]) begin
        freeIdx   = IDX_W'(i);
        freeFound = 1'b1;
      end
    end
  end

  assign tlbHit = |hitVec;

  logic [FRAME_W-1:0] hitFrame;
  logic               hitWr;
  assign hitFrame = slotFrame[hitIdx];
  assign hitWr    = slotWr[hitIdx];

  // fill decision
  logic             installEn;
  logic [IDX_W-1:0] installIdx;
  logic [IDX_W-1:0] victimPtr;

  assign installEn  = strobe.doFill && pteValid && !flush &&
                      !(tblWe && (tblPage == latPage));
  assign installIdx = freeFound ? freeIdx : victimPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (installEn && !freeFound) begin
      victimPtr <= (victimPtr == IDX_W'(TLB_N - 1)) ? '0 : victimPtr + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < TLB_N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
      end else if (flush) begin
        slotValid[g] <= 1'b0;
      end else if (installEn && (installIdx == IDX_W'(g))) begin
        slotValid[g] <= 1'b1;
      end else if (tblWe && (slotPage[g] == tblPage)) begin
        slotValid[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (installEn && (installIdx == IDX_W'(g))) begin
        slotPage[g]  <= latPage;
        slotFrame[g] <= pteFrame;
        slotWr[g]    <= pteWritable;
      end
    end
  end

  // result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAddr  <= '0;
      respFault <= FAULT_NONE;
    end else begin
      respValid <= strobe.acceptHit || strobe.doFill;
      if (strobe.acceptHit) begin
        if (reqWrite && !hitWr) begin
          respFault <= FAULT_PROTECT;
          respAddr  <= '0;
        end else begin
          respFault <= FAULT_NONE;
          respAddr  <= {hitFrame, reqOff};
        end
      end else if (strobe.doFill) begin
        if (!pteValid) begin
          respFault <= FAULT_INVALID;
          respAddr  <= '0;
        end else if (latWrite && !pteWritable) begin
          respFault <= FAULT_PROTECT;
          respAddr  <= '0;
        end else begin
          respFault <= FAULT_NONE;
          respAddr  <= PHYS_W'({pteFrame, latOff});
        end
      end
    end
  end

  // R5: a page is cached in at most one slot
  assert_slot_unique_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R6: a flush leaves every slot empty
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> slotValid == '0);

  // R1: an accepted hit is answered on the next cycle
  assert_hit_answer_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptHit |=> respValid);

  // R3: a faulting result carries no address
  assert_fault_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault != FAULT_NONE) |-> respAddr == '0);

  // R10: a fill whose map entry is rewritten in the same cycle installs nothing
  assert_race_no_install_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doFill && tblWe && tblPage == latPage && !tlbHit && !flush) |=>
      slotValid == $past(slotValid) & ~$past(hitVec));

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
  import xlate_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int TLB_N   = 4,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [PAGE_W+OFF_W-1:0]  reqAddr,
  input  logic                     reqWrite,
  output logic                     busy,
  output logic                     respValid,
  output logic [FRAME_W+OFF_W-1:0] respAddr,
  output logic [1:0]               respFault,
  input  logic                     flush,
  input  logic                     tblWe,
  input  logic [PAGE_W-1:0]        tblPage,
  input  logic [FRAME_W-1:0]       tblFrame,
  input  logic                     tblValid,
  input  logic                     tblWritable,
  output logic [CNT_W-1:0]         hitCount,
  output logic [CNT_W-1:0]         missCount
);

  ctrlStrobe_t        strobe;
  logic               tlbHit;
  logic [PAGE_W-1:0]  ptIdx;
  logic [FRAME_W-1:0] pteFrame;
  logic               pteValid;
  logic               pteWritable;

  xlate_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .tlbHit    (tlbHit),
    .busy      (busy),
    .strobe    (strobe),
    .hitCount  (hitCount),
    .missCount (missCount)
  );

  xlate_datapath #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .FRAME_W(FRAME_W),
    .TLB_N  (TLB_N)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .strobe     (strobe),
    .flush      (flush),
    .tblWe      (tblWe),
    .tblPage    (tblPage),
    .tlbHit     (tlbHit),
    .ptIdx      (ptIdx),
    .pteFrame   (pteFrame),
    .pteValid   (pteValid),
    .pteWritable(pteWritable),
    .respValid  (respValid),
    .respAddr   (respAddr),
    .respFault  (respFault)
  );

  xlate_ptable #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) i_ptable (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (tblWe),
    .wrPage    (tblPage),
    .wrFrame   (tblFrame),
    .wrValid   (tblValid),
    .wrWritable(tblWritable),
    .rdPage    (ptIdx),
    .rdFrame   (pteFrame),
    .rdValid   (pteValid),
    .rdWritable(pteWritable)
  );

endmodule

// File: tb/test_paged_xlate.sv
module test_paged_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        busy;
  logic        respValid;
  logic [15:0] respAddr;
  logic [1:0]  respFault;
  logic        flush = 1'b0;
  logic        tblWe = 1'b0;
  logic [7:0]  tblPage = '0;
  logic [7:0]  tblFrame = '0;
  logic        tblValid = 1'b0;
  logic        tblWritable = 1'b0;
  logic [15:0] hitCount;
  logic [15:0] missCount;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  paged_xlate i_paged_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .busy(busy), .respValid(respValid),
    .respAddr(respAddr), .respFault(respFault), .flush(flush),
    .tblWe(tblWe), .tblPage(tblPage), .tblFrame(tblFrame),
    .tblValid(tblValid), .tblWritable(tblWritable),
    .hitCount(hitCount), .missCount(missCount)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic        expHit;
    logic [1:0]  expFault;
    logic [15:0] expAddr;
  } vec_t;

  // map: pages 0..5 present, frame 0x40+page, even pages writable; 6,7 absent
  localparam vec_t VECS [14] = '{
    '{1'b0, 16'h0112, 1'b0, 2'd0, 16'h4112},  // miss, slot0 <- p1
    '{1'b0, 16'h0134, 1'b1, 2'd0, 16'h4134},
    '{1'b1, 16'h0105, 1'b1, 2'd2, 16'h0000},  // write read-only page
    '{1'b1, 16'h0206, 1'b0, 2'd0, 16'h4206},  // slot1 <- p2
    '{1'b0, 16'h06AA, 1'b0, 2'd1, 16'h0000},  // absent page
    '{1'b0, 16'h06AA, 1'b0, 2'd1, 16'h0000},  // still not cached
    '{1'b0, 16'h03FF, 1'b0, 2'd0, 16'h43FF},  // slot2 <- p3
    '{1'b1, 16'h0000, 1'b0, 2'd0, 16'h4000},  // slot3 <- p0, full
    '{1'b0, 16'h0201, 1'b1, 2'd0, 16'h4201},
    '{1'b0, 16'h0400, 1'b0, 2'd0, 16'h4400},  // victim slot0 (p1)
    '{1'b0, 16'h0110, 1'b0, 2'd0, 16'h4110},  // victim slot1 (p2)
    '{1'b0, 16'h0211, 1'b0, 2'd0, 16'h4211},  // victim slot2 (p3)
    '{1'b0, 16'h0000, 1'b1, 2'd0, 16'h4000},  // p0 kept in slot3
    '{1'b0, 16'h0410, 1'b1, 2'd0, 16'h4410}
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [15:0] addr,
                       output logic gotHit, output logic gotValid,
                       output logic [1:0] gotFault, output logic [15:0] gotAddr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    if (busy) begin
      gotHit = 1'b0;
      @(negedge clk);
    end else begin
      gotHit = 1'b1;
    end
    gotValid = respValid; gotFault = respFault; gotAddr = respAddr;
  endtask

  task automatic mapWrite(input logic [7:0] pg, input logic [7:0] fr,
                          input logic v, input logic w);
    @(negedge clk);
    tblWe = 1'b1; tblPage = pg; tblFrame = fr; tblValid = v; tblWritable = w;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic reqCheck(input string tag, input logic wr, input logic [15:0] addr,
                          input logic expHit, input logic [1:0] expFault,
                          input logic [15:0] expAddr);
    logic h, v;
    logic [1:0] f;
    logic [15:0] a;
    doReq(wr, addr, h, v, f, a);
    check(tag, "hit", 32'(h), 32'(expHit));
    check(tag, "valid", 32'(v), 32'd1);
    check(tag, "fault", 32'(f), 32'(expFault));
    check(tag, "addr", 32'(a), 32'(expAddr));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", "respValid", 32'(respValid), 32'd0);
    check("R11", "busy", 32'(busy), 32'd0);
    check("R11", "hitCount", 32'(hitCount), 32'd0);
    check("R11", "missCount", 32'(missCount), 32'd0);
    // R11: map empty after reset -> missing-page fault
    reqCheck("R11", 1'b0, 16'h0012, 1'b0, 2'd1, 16'h0000);

    for (int p = 0; p < 8; p++) begin
      mapWrite(8'(p), 8'(8'h40 + p), (p < 6), (p % 2 == 0));
    end

    for (int k = 0; k < 14; k++) begin
      string tag;
      if (VECS[k].expFault == 2'd1) tag = "R3";
      else if (VECS[k].expFault == 2'd2) tag = "R4";
      else if (k >= 9) tag = "R5";
      else if (VECS[k].expHit) tag = "R1";
      else tag = "R2";
      reqCheck(tag, VECS[k].wr, VECS[k].addr, VECS[k].expHit,
               VECS[k].expFault, VECS[k].expAddr);
    end

    // R9: 5 hits, 10 misses including the reset probe
    check("R9", "hitCount", 32'(hitCount), 32'd5);
    check("R9", "missCount", 32'(missCount), 32'd10);

    // R6: flush empties the cache
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    reqCheck("R6", 1'b0, 16'h0400, 1'b0, 2'd0, 16'h4400);

    // R8: request held during the fill cycle is ignored
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'h0500; reqWrite = 1'b0;
    @(negedge clk);
    check("R8", "busy", 32'(busy), 32'd1);
    reqAddr = 16'h0400;
    @(negedge clk);
    check("R8", "resp", 32'({respValid, respFault, respAddr}), 32'({1'b1, 2'd0, 16'h4500}));
    check("R8", "hitCount", 32'(hitCount), 32'd5);
    check("R8", "missCount", 32'(missCount), 32'd12);
    reqValid = 1'b0;
    @(negedge clk);
    check("R8", "no extra result", 32'(respValid), 32'd0);

    // R7: map write drops only that page's cached copy
    mapWrite(8'h04, 8'h99, 1'b1, 1'b1);
    reqCheck("R7", 1'b0, 16'h0401, 1'b0, 2'd0, 16'h9901);
    reqCheck("R7", 1'b0, 16'h0502, 1'b1, 2'd0, 16'h4502);

    // R10: map write to the page being filled, in its fill cycle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'h0300; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "busy", 32'(busy), 32'd1);
    tblWe = 1'b1; tblPage = 8'h03; tblFrame = 8'h77; tblValid = 1'b1; tblWritable = 1'b1;
    @(negedge clk);
    tblWe = 1'b0;
    check("R10", "old entry used", 32'({respValid, respFault, respAddr}),
          32'({1'b1, 2'd0, 16'h4300}));
    reqCheck("R10", 1'b0, 16'h0301, 1'b0, 2'd0, 16'h7701);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule